// File: doc/BRIEF.md
# Packet DMA Buffer Pointer Controller

This block keeps the memory pointers for one channel of a packet DMA engine that moves 32-bit quadlets between a serial link and system memory. It holds two buffer descriptors. The current buffer has a running address and a final address. The next buffer is written by software and has a start address, an end address and a ready flag. When the channel has no current buffer and the ready flag is set, the block takes up the next buffer. It then steps the running address by one quadlet for each quadlet transferred. It releases the buffer at the end of the packet that carries the address past the final one.

In receive mode the block saves the running address when each packet begins. If the packet is aborted for any reason (a break or a protocol error), it winds the address back, so the next packet lands on top of the discarded data. Receive packet lengths come from the packet header, so the last packet of a buffer may run beyond the final address. The block never cuts such a packet short. In transmit mode software knows the exact length, and abort strobes leave the address alone. A buffer that holds one packet is set up by giving it the same start and end address.

Top module: `pkt_dma_bufptr`

## Requirements
- R1: Take-up happens on the first rising edge at which the channel holds no current buffer and the ready flag is set. On that edge the stored next-buffer start address is loaded into `cur_addr_o` and the end address into `cur_final_o`, with bits [1:0] of both forced to 0. `buf_start_o` is high for exactly the following cycle.
- R2: Take-up clears `rdy_o`. `rdy_set_i` sets the flag on any other edge. A write with `nb_wr_i` changes only the stored next-buffer addresses and never the current ones.
- R3: While a buffer is held, each cycle with `qd_valid_i` high and no abort in effect adds 4 to `cur_addr_o`.
- R4: In receive mode (`rx_mode_i`=1), `pkt_start_i` saves `cur_addr_o`. A later `abort_i` puts `cur_addr_o` back to the saved value, so the next packet reuses the same addresses.
- R5: In transmit mode (`rx_mode_i`=0), `abort_i` has no effect on `cur_addr_o`.
- R6: Quadlets that arrive after `cur_addr_o` has passed `cur_final_o` still advance the address. Only `pkt_end_i` releases a buffer.
- R7: On `pkt_end_i` while a buffer is held, the buffer is released if `cur_addr_o` > `cur_final_o`. `buf_done_o` is then high for exactly the next cycle. If `cur_addr_o` <= `cur_final_o`, the buffer is kept and no done pulse is raised.
- R8: A buffer whose start and end addresses are equal completes at the end of its first packet, whatever that packet's length.
- R9: With no buffer held and the ready flag clear, `not_ready_o` is high, `active_o` is low, and quadlet strobes leave `cur_addr_o` unchanged.
- R10: After reset, both addresses are 0, `rdy_o`, `active_o` and both interrupt pulses are 0, and `not_ready_o` is 1.
- R11: `buf_start_o` and `buf_done_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_mode_i | input | 1 | 1 = receive channel, 0 = transmit channel |
| nb_wr_i | input | 1 | Write the next-buffer start and end addresses |
| nb_start_i | input | 32 | Next-buffer start byte address |
| nb_end_i | input | 32 | Next-buffer end byte address (inclusive last quadlet) |
| rdy_set_i | input | 1 | Set the next-buffer ready flag |
| pkt_start_i | input | 1 | First cycle of a packet |
| qd_valid_i | input | 1 | One quadlet transferred |
| pkt_end_i | input | 1 | Packet completed successfully |
| abort_i | input | 1 | Packet aborted (break or protocol error) |
| cur_addr_o | output | 32 | Address of the quadlet being processed |
| cur_final_o | output | 32 | Final address of the current buffer |
| rdy_o | output | 1 | Next-buffer ready flag |
| active_o | output | 1 | A current buffer is held and quadlets are accepted |
| not_ready_o | output | 1 | Stalled: no buffer held and no next buffer ready |
| buf_start_o | output | 1 | One-cycle buffer-start interrupt |
| buf_done_o | output | 1 | One-cycle buffer-done interrupt |

## Verification
The assertions check on every cycle that a take-up copies the stored descriptor and clears the ready flag, that an accepted quadlet moves the address by exactly 4, and that a transmit abort holds it steady. They also check that the two interrupts are single-cycle pulses that never overlap, and that a stall never coincides with an active buffer. Only the bench scenarios can show the longer orderings. These are a receive packet rolled back to the address saved several cycles earlier, a last packet that overruns the final address without being cut, a single-packet buffer completing, and a stall that ends when software sets the ready flag.

// File: rtl/pdb_pkg.sv
package pdb_pkg;
  parameter int unsigned ADDR_W     = 32;
  parameter int unsigned QUAD_BYTES = 4;
  localparam int unsigned ALIGN_W   = $clog2(QUAD_BYTES);

  typedef enum logic {
    BUF_EMPTY  = 1'b0,
    BUF_ACTIVE = 1'b1
  } buf_state_e;
endpackage

// File: rtl/pdb_next_desc.sv
module pdb_next_desc #(
  parameter int unsigned AW = pdb_pkg::ADDR_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [AW-1:0] start_i,
  input  logic [AW-1:0] end_i,
  input  logic          rdy_set_i,
  input  logic          take_i,
  output logic [AW-1:0] start_o,
  output logic [AW-1:0] end_o,
  output logic          rdy_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_o <= '0;
      end_o   <= '0;
      rdy_o   <= 1'b0;
    end else begin
      if (wr_i) begin
        start_o <= start_i;
        end_o   <= end_i;
      end
      // take-up wins over a same-cycle set
      if (take_i)         rdy_o <= 1'b0;
      else if (rdy_set_i) rdy_o <= 1'b1;
    end
  end

  AST_TAKE_CLEARS_RDY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |=> !rdy_o); // R2
endmodule

// File: rtl/pdb_addr_unit.sv
module pdb_addr_unit #(
  parameter int unsigned AW = pdb_pkg::ADDR_W,
  parameter int unsigned QB = pdb_pkg::QUAD_BYTES
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          take_i,
  input  logic [AW-1:0] nb_start_i,
  input  logic [AW-1:0] nb_end_i,
  input  logic          active_i,
  input  logic          rx_i,
  input  logic          pkt_start_i,
  input  logic          qd_i,
  input  logic          abort_i,
  output logic [AW-1:0] cur_o,
  output logic [AW-1:0] fin_o,
  output logic          past_final_o
);
  localparam int unsigned AL = $clog2(QB);
  localparam logic [AW-1:0] STEP = AW'(QB);
  localparam logic [AW-1:0] MASK = ~AW'((1 << AL) - 1);

  logic [AW-1:0] shadow_q;
  logic          rollback;

  assign rollback     = active_i && rx_i && abort_i;
  assign past_final_o = cur_o > fin_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_o    <= '0;
      fin_o    <= '0;
      shadow_q <= '0;
    end else if (take_i) begin
      cur_o <= nb_start_i & MASK;
      fin_o <= nb_end_i & MASK;
    end else if (active_i) begin
      if (rollback)  cur_o <= shadow_q;
      else if (qd_i) cur_o <= cur_o + STEP;
      if (rx_i && pkt_start_i) shadow_q <= cur_o;
    end
  end

  AST_QUAD_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && qd_i && !abort_i && !take_i) |=> cur_o == $past(cur_o) + STEP); // R3
  AST_TX_ABORT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && !rx_i && abort_i && !qd_i && !take_i) |=> $stable(cur_o)); // R5
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active_i && !take_i) |=> $stable(cur_o) && $stable(fin_o)); // R9
endmodule

// File: rtl/pdb_ctrl.sv
module pdb_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rdy_i,
  input  logic pkt_end_i,
  input  logic past_final_i,
  output logic take_o,
  output logic active_o,
  output logic not_ready_o,
  output logic buf_start_o,
  output logic buf_done_o
);
  import pdb_pkg::*;

  buf_state_e state_q;
  logic       done_now;

  assign active_o    = (state_q == BUF_ACTIVE);
  assign take_o      = (state_q == BUF_EMPTY) && rdy_i;
  assign done_now    = active_o && pkt_end_i && past_final_i;
  assign not_ready_o = (state_q == BUF_EMPTY) && !rdy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= BUF_EMPTY;
      buf_start_o <= 1'b0;
      buf_done_o  <= 1'b0;
    end else begin
      buf_start_o <= take_o;
      buf_done_o  <= done_now;
      if (take_o)        state_q <= BUF_ACTIVE;
      else if (done_now) state_q <= BUF_EMPTY;
    end
  end

  AST_PULSE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(buf_start_o && buf_done_o)); // R11
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_done_o |=> !buf_done_o); // R7
  AST_START_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_start_o |=> !buf_start_o); // R1
  AST_STALL_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    not_ready_o |-> !active_o); // R9
endmodule

// File: rtl/pkt_dma_bufptr.sv
module pkt_dma_bufptr #(
  parameter int unsigned AW = pdb_pkg::ADDR_W,
  parameter int unsigned QB = pdb_pkg::QUAD_BYTES
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rx_mode_i,
  input  logic          nb_wr_i,
  input  logic [AW-1:0] nb_start_i,
  input  logic [AW-1:0] nb_end_i,
  input  logic          rdy_set_i,
  input  logic          pkt_start_i,
  input  logic          qd_valid_i,
  input  logic          pkt_end_i,
  input  logic          abort_i,
  output logic [AW-1:0] cur_addr_o,
  output logic [AW-1:0] cur_final_o,
  output logic          rdy_o,
  output logic          active_o,
  output logic          not_ready_o,
  output logic          buf_start_o,
  output logic          buf_done_o
);
  localparam logic [AW-1:0] MASK = ~AW'(QB - 1);

  logic [AW-1:0] nb_start_q, nb_end_q;
  logic          take, past_final;

  pdb_next_desc #(.AW(AW)) u_next (
    .clk_i, .rst_ni,
    .wr_i(nb_wr_i), .start_i(nb_start_i), .end_i(nb_end_i),
    .rdy_set_i, .take_i(take),
    .start_o(nb_start_q), .end_o(nb_end_q), .rdy_o
  );

  pdb_ctrl u_ctrl (
    .clk_i, .rst_ni,
    .rdy_i(rdy_o), .pkt_end_i, .past_final_i(past_final),
    .take_o(take), .active_o, .not_ready_o, .buf_start_o, .buf_done_o
  );

  pdb_addr_unit #(.AW(AW), .QB(QB)) u_addr (
    .clk_i, .rst_ni,
    .take_i(take), .nb_start_i(nb_start_q), .nb_end_i(nb_end_q),
    .active_i(active_o), .rx_i(rx_mode_i),
    .pkt_start_i, .qd_i(qd_valid_i), .abort_i,
    .cur_o(cur_addr_o), .fin_o(cur_final_o), .past_final_o(past_final)
  );

  AST_TAKE_LOADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_start_o |-> (cur_addr_o == ($past(nb_start_q) & MASK))
                 && (cur_final_o == ($past(nb_end_q) & MASK))); // R1
  AST_TAKE_RDY_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_start_o |-> !rdy_o && active_o); // R2
endmodule

// File: tb/pkt_dma_bufptr_tb.sv
module pkt_dma_bufptr_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic rx = 1'b1, nbw = 0, rset = 0, ps = 0, qd = 0, pe = 0, ab = 0;
  logic [31:0] nbs = 0, nbe = 0;
  logic [31:0] cur, fin;
  logic rdy, act, nrdy, bs, bd;

  pkt_dma_bufptr dut_i (
    .clk_i(clk), .rst_ni(rst_n), .rx_mode_i(rx), .nb_wr_i(nbw),
    .nb_start_i(nbs), .nb_end_i(nbe), .rdy_set_i(rset),
    .pkt_start_i(ps), .qd_valid_i(qd), .pkt_end_i(pe), .abort_i(ab),
    .cur_addr_o(cur), .cur_final_o(fin), .rdy_o(rdy), .active_o(act),
    .not_ready_o(nrdy), .buf_start_o(bs), .buf_done_o(bd)
  );

  int checks = 0, fails = 0;
  logic [31:0] m_cur = 0, m_fin = 0, m_sh = 0, m_nbs = 0, m_nbe = 0;
  logic m_have = 0, m_rdy = 0, m_bs = 0, m_bd = 0;

  task automatic chk(string tag, logic [31:0] a, logic [31:0] e);
    checks++;
    if (a !== e) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, a, e);
    end
  endtask

  // Cycle model built from the requirements
  function automatic void model_step();
    logic [31:0] n_cur = m_cur, n_fin = m_fin, n_sh = m_sh;
    logic n_have = m_have, n_rdy = m_rdy, n_bs = 0, n_bd = 0, tk;
    tk = !m_have && m_rdy;
    if (tk) begin
      n_cur = m_nbs & ~32'h3; n_fin = m_nbe & ~32'h3; n_have = 1; n_bs = 1;
    end else if (m_have) begin
      if (rx && ab) n_cur = m_sh;
      else if (qd) n_cur = m_cur + 4;
      if (rx && ps) n_sh = m_cur;
      if (pe && m_cur > m_fin) begin n_have = 0; n_bd = 1; end
    end
    if (tk) n_rdy = 0; else if (rset) n_rdy = 1;
    if (nbw) begin m_nbs = nbs; m_nbe = nbe; end
    m_cur = n_cur; m_fin = n_fin; m_sh = n_sh; m_have = n_have;
    m_rdy = n_rdy; m_bs = n_bs; m_bd = n_bd;
  endfunction

  task automatic compare(string tag);
    chk({tag, " cur"}, cur, m_cur);
    chk({tag, " fin"}, fin, m_fin);
    chk({tag, " ctl"}, {27'd0, rdy, act, nrdy, bs, bd},
        {27'd0, m_rdy, m_have, !m_have && !m_rdy, m_bs, m_bd});
  endtask

  task automatic cyc(string tag);
    @(posedge clk);
    model_step();
    #1;
    compare(tag);
    {nbw, rset, ps, qd, pe, ab} = '0;
  endtask

  task automatic quads(int n, string tag);
    for (int i = 0; i < n; i++) begin qd = 1; cyc(tag); end
  endtask

  task automatic setbuf(logic [31:0] s, logic [31:0] e);
    nbw = 1; nbs = s; nbe = e; rset = 1; cyc("R2 write");
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    #23 rst_n = 1'b1;
    @(negedge clk);
    chk("R10 cur", cur, 0); chk("R10 flags", {rdy, act, bs, bd}, 0);
    chk("R10 R9 not_ready", {31'd0, nrdy}, 1);
    @(posedge clk); #1;

    // receive, multi-packet buffer 0x1000..0x100C
    setbuf(32'h1000, 32'h100C);
    chk("R2 rdy set", {31'd0, rdy}, 1);
    cyc("R1 take");
    chk("R1 cur", cur, 32'h1000); chk("R1 fin", fin, 32'h100C);
    chk("R1 R2 pulse", {30'd0, bs, rdy}, 2'b10);
    setbuf(32'h2000, 32'h2000);  // next buffer staged, current unaffected
    chk("R2 nb_wr isolation", cur, 32'h1000);
    ps = 1; cyc("R4 start");
    quads(3, "R3");
    chk("R3 step", cur, 32'h100C);
    pe = 1; cyc("R7 no done");
    chk("R7 kept", {30'd0, bd, act}, 2'b01);
    ps = 1; cyc("R4 start2");
    quads(2, "R3");
    ab = 1; cyc("R4 abort");
    chk("R4 restore", cur, 32'h100C);
    ps = 1; cyc("R4 reuse");
    quads(3, "R6");
    chk("R6 overrun", cur, 32'h1018);
    pe = 1; cyc("R7 done");
    chk("R7 pulse", {31'd0, bd}, 1);
    cyc("R1 take2");
    chk("R1 take2 cur", cur, 32'h2000);
    // single-packet buffer: start == end
    ps = 1; cyc("R8 start");
    quads(5, "R8");
    pe = 1; cyc("R8 done");
    chk("R8 pulse", {31'd0, bd}, 1);
    cyc("R9 idle");
    chk("R9 stall", {30'd0, nrdy, act}, 2'b10);
    quads(2, "R9");
    chk("R9 no advance", cur, 32'h2014);

    // transmit buffer 0x3000..0x3008, unaligned bits dropped
    rx = 0;
    setbuf(32'h3002, 32'h300B);
    cyc("R1 tx take");
    chk("R1 align", fin, 32'h3008);
    ps = 1; cyc("R5 start");
    quads(2, "R5");
    ab = 1; cyc("R5 abort");
    chk("R5 hold", cur, 32'h3008);
    quads(1, "R5");
    pe = 1; cyc("R7 tx done");
    chk("R7 tx pulse", {31'd0, bd}, 1);

    // random traffic
    for (int k = 0; k < 4000; k++) begin
      int r;
      r = int'($urandom % 20);
      if (r < 8) qd = 1;
      else if (r < 10) ps = 1;
      else if (r < 12) pe = 1;
      else if (r < 13) ab = 1;
      else if (r < 15) begin
        nbw = 1; nbs = {16'h0, 6'($urandom), 10'h0}; nbe = nbs + 4 * ($urandom % 6);
      end else if (r < 17) rset = 1;
      else if (r == 17 && !m_have) rx = ~rx;
      cyc("R3 R4 R7 random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule